// File: doc/BRIEF.md
# Multiplexed-Address Grid RAM

A 1024-word by 8-bit synchronous memory whose word array is organised as a 32 x 32 grid. A 10-bit logical word address reaches the block over a shared 5-bit address bus in two halves. The upper half (the row) is taken when the row strobe rises. The lower half (the column) is taken when the column strobe rises. Only a column strobe starts an access. That access uses whichever row was captured most recently.

A captured access is carried out on the following clock edge. One 5-to-32 decoder picks a row line and a second 5-to-32 decoder picks a column line. The word where the two active lines cross is written and/or read. Read data is registered. A one-cycle valid pulse marks each read result. Data in and data out are separate ports, and there is no tri-state bus.

Top module: `muxaddr_ram`

## Requirements
- R1: After a synchronous active-low reset, `rd_data_o` is 0, `rd_valid_o` is 0, and every one of the 1024 words reads as 0.
- R2: A strobe event is a clock edge at which the strobe is sampled high after being sampled low on the previous edge. On a row strobe event, the 5-bit bus value becomes the latched row, which is address bits [9:5].
- R3: A column strobe event, sampled with enable high, starts an access once a row has been latched since reset. The bus value is the column, which is address bits [4:0]. The word address is {row, column}.
- R4: A column strobe event that comes before any row strobe event since reset is ignored. It writes nothing and produces no valid pulse.
- R5: When `wr_i`=1 is sampled with the column event, the word is overwritten with `wr_data_i` sampled at that edge. The new value is visible to any later access.
- R6: When `rd_i`=1 is sampled with the column event, `rd_data_o` holds the word and `rd_valid_o` is 1 after the next clock edge. This is one cycle after the capture edge. The valid flag is a single-cycle pulse.
- R7: When `rd_i` and `wr_i` are both 1, the write takes place and the read returns the contents from before that write.
- R8: When enable is low at the column event, nothing is written, `rd_valid_o` stays 0 and `rd_data_o` keeps its previous value.
- R9: An enabled column event with `rd_i`=0 and `wr_i`=0 changes no word, gives no valid pulse and leaves `rd_data_o` unchanged.
- R10: When row and column events fall on the same edge, the column uses the previously latched row, and the bus value becomes the row for later accesses. If no row was latched before that edge, the column event is ignored.
- R11: During an access, each decoder output is one-hot, so exactly one word is touched. When no access is in progress, both decoder outputs are all zero.
- R12: A strobe held high for several cycles counts as one event only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 5 | Shared row/column address bus |
| ras_i | input | 1 | Row address strobe |
| cas_i | input | 1 | Column address strobe, starts an access |
| en_i | input | 1 | Access enable, sampled with the column event |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | One-cycle read-data valid pulse |

## Verification
Three coincidences are the interesting ones. First, a new row can be latched on the same edge as a column event. The bench raises both strobes together with the bus carrying one value and then checks which word the access touched. It also checks which row a later lone column event uses. Second, a read and a write can target the same word on the same edge. The bench sets both requests and expects the old contents on the data output while the next read returns the new data. Third, an access from an earlier capture executes on the same edge as a new strobe capture. Back-to-back strobe sequences are judged every cycle against a behavioural model that keeps its own pending access and memory contents.

// File: rtl/mar_pkg.sv
// Package: shared types for the multiplexed-address grid RAM.
// Assumes nothing beyond IEEE 1800-2017 enums.
package mar_pkg;

    // Operation captured with a column strobe event
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RDWR  = 2'b11
    } op_e;

    // Default geometry
    localparam int DEF_ROW_BITS = 5;
    localparam int DEF_COL_BITS = 5;
    localparam int DEF_DATA_W   = 8;

endpackage

// File: rtl/mar_strobe_latch.sv
// Module: strobe edge detection and address capture.
// Turns the row and column strobes into single-edge events. It keeps the most
// recent row, and on a column event it registers one complete access request
// (row snapshot, column, operation, write data).
// Assumes: the row and column halves have the same width, since they share
// the bus. The strobes are synchronous to clk.
module mar_strobe_latch
    import mar_pkg::*;
#(
    parameter int AW = DEF_ROW_BITS,
    parameter int DW = DEF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          ras_i,
    input  logic          cas_i,
    input  logic          en_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          acc_vld_o,
    output logic [AW-1:0] acc_row_o,
    output logic [AW-1:0] acc_col_o,
    output op_e           acc_op_o,
    output logic [DW-1:0] acc_wdata_o
);

    logic          ras_d, cas_d;
    logic          ras_evt, cas_evt;
    logic          row_ok;
    logic [AW-1:0] row_q;
    op_e           op_sel;

    // Rising-edge detection on the sampled strobes
    assign ras_evt = ras_i & ~ras_d;
    assign cas_evt = cas_i & ~cas_d;

    // Operation code from the two request bits
    always_comb begin
        case ({wr_i, rd_i})
            2'b01:   op_sel = OP_READ;
            2'b10:   op_sel = OP_WRITE;
            2'b11:   op_sel = OP_RDWR;
            default: op_sel = OP_NONE;
        endcase
    end

    // Strobe history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_d <= 1'b0;
            cas_d <= 1'b0;
        end else begin
            ras_d <= ras_i;
            cas_d <= cas_i;
        end
    end

    // Row latch: bus value taken on each row event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            row_ok <= 1'b0;
        end else if (ras_evt) begin
            row_q  <= addr_i;
            row_ok <= 1'b1;
        end
    end

    // Access capture on a column event, using the row held before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vld_o   <= 1'b0;
            acc_row_o   <= '0;
            acc_col_o   <= '0;
            acc_op_o    <= OP_NONE;
            acc_wdata_o <= '0;
        end else begin
            acc_vld_o <= cas_evt & row_ok & en_i;
            if (cas_evt) begin
                acc_row_o   <= row_q;
                acc_col_o   <= addr_i;
                acc_op_o    <= op_sel;
                acc_wdata_o <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/mar_decoder.sv
// Module: gated binary to one-hot decoder.
// Drives exactly one of 2**IN_W lines while en_i is high and none otherwise.
// Assumes: IN_W is small enough that 2**IN_W lines is practical.
module mar_decoder #(
    parameter int IN_W = 5,
    localparam int N   = 1 << IN_W
) (
    input  logic            en_i,
    input  logic [IN_W-1:0] sel_i,
    output logic [N-1:0]    hot_o
);

    // One comparator per output line
    for (genvar i = 0; i < N; i++) begin : g_line
        assign hot_o[i] = en_i && (sel_i == IN_W'(i));
    end

endmodule

// File: rtl/mar_cell_array.sv
// Module: word storage grid with coincident selection.
// A cell is written when its row line and column line are both active and
// we_i is high. Read data is an AND-OR of every cell gated by its row and
// column lines. It is combinational and shows contents from before any write
// on the same edge.
// Assumes: row_hot_i and col_hot_i are each one-hot or all zero.
module mar_cell_array #(
    parameter int ROW_BITS = 5,
    parameter int COL_BITS = 5,
    parameter int DW       = 8,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = 1 << COL_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_hot_i,
    input  logic [COLS-1:0] col_hot_i,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o
);

    logic [ROWS*DW-1:0] row_pick;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS*DW-1:0] masked;
        logic [DW-1:0]      row_or;

        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [DW-1:0] cell_q;

            // Storage cell written at its row/column crossing
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (we_i && row_hot_i[r] && col_hot_i[c])
                    cell_q <= wdata_i;
            end

            assign masked[c*DW +: DW] = col_hot_i[c] ? cell_q : '0;
        end

        // Column merge within the row
        always_comb begin
            row_or = '0;
            for (int c = 0; c < COLS; c++)
                row_or = row_or | masked[c*DW +: DW];
        end

        assign row_pick[r*DW +: DW] = row_hot_i[r] ? row_or : '0;
    end

    // Row merge into the read word
    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < ROWS; r++)
            rdata_o = rdata_o | row_pick[r*DW +: DW];
    end

endmodule

// File: rtl/muxaddr_ram.sv
// Module: top of the multiplexed-address grid RAM.
// The address arrives in two halves on a shared bus. A column event captures
// an access, and one cycle later the two decoders select the word, which is
// written and/or read into a registered output with a valid pulse.
// Assumes: the row and column halves have equal width (shared bus).
module muxaddr_ram
    import mar_pkg::*;
#(
    parameter int ROW_BITS = DEF_ROW_BITS,
    parameter int COL_BITS = DEF_COL_BITS,
    parameter int DATA_W   = DEF_DATA_W,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int COLS    = 1 << COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_BITS-1:0] addr_i,
    input  logic                ras_i,
    input  logic                cas_i,
    input  logic                en_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                rd_valid_o
);

    logic                acc_vld;
    logic [ROW_BITS-1:0] acc_row;
    logic [ROW_BITS-1:0] acc_col;
    op_e                 acc_op;
    logic [DATA_W-1:0]   acc_wdata;
    logic [ROWS-1:0]     row_hot;
    logic [COLS-1:0]     col_hot;
    logic [DATA_W-1:0]   cell_rdata;
    logic                do_write, do_read;

    mar_strobe_latch #(.AW(ROW_BITS), .DW(DATA_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .ras_i       (ras_i),
        .cas_i       (cas_i),
        .en_i        (en_i),
        .rd_i        (rd_i),
        .wr_i        (wr_i),
        .wr_data_i   (wr_data_i),
        .acc_vld_o   (acc_vld),
        .acc_row_o   (acc_row),
        .acc_col_o   (acc_col),
        .acc_op_o    (acc_op),
        .acc_wdata_o (acc_wdata)
    );

    mar_decoder #(.IN_W(ROW_BITS)) u_row_dec (
        .en_i  (acc_vld),
        .sel_i (acc_row),
        .hot_o (row_hot)
    );

    mar_decoder #(.IN_W(COL_BITS)) u_col_dec (
        .en_i  (acc_vld),
        .sel_i (acc_col[COL_BITS-1:0]),
        .hot_o (col_hot)
    );

    assign do_write = acc_vld && (acc_op == OP_WRITE || acc_op == OP_RDWR);
    assign do_read  = acc_vld && (acc_op == OP_READ  || acc_op == OP_RDWR);

    mar_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_hot_i (row_hot),
        .col_hot_i (col_hot),
        .we_i      (do_write),
        .wdata_i   (acc_wdata),
        .rdata_o   (cell_rdata)
    );

    // Registered read port: data held between reads, valid pulses per read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= do_read;
            if (do_read)
                rd_data_o <= cell_rdata;
        end
    end

endmodule

// File: rtl/muxaddr_ram_checker.sv
// Module: protocol and decoder checks for muxaddr_ram, attached by bind.
// Assumes: the strobes are synchronous and reset is active-low.
module muxaddr_ram_checker #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_i,
    input logic            cas_i,
    input logic            en_i,
    input logic [DW-1:0]   rd_data_o,
    input logic            rd_valid_o,
    input logic            acc_vld,
    input logic [ROWS-1:0] row_hot,
    input logic [COLS-1:0] col_hot
);

    logic row_seen;

    // Tracks whether any row event has been sampled since reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_seen <= 1'b0;
        else if (ras_i && !$past(ras_i))
            row_seen <= 1'b1;
    end

    a_r11_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld ? ($countones(row_hot) == 1) : (row_hot == '0));

    a_r11_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld ? ($countones(col_hot) == 1) : (col_hot == '0));

    a_r8_disabled_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_i && !$past(cas_i) && !en_i) |=> ##1 !rd_valid_o);

    a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> $stable(rd_data_o));

    a_r4_no_row_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_i && !$past(cas_i) && !row_seen) |=> ##1 !rd_valid_o);

    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

endmodule

bind muxaddr_ram muxaddr_ram_checker #(
    .ROWS (1 << ROW_BITS),
    .COLS (1 << COL_BITS),
    .DW   (DATA_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_i      (ras_i),
    .cas_i      (cas_i),
    .en_i       (en_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .acc_vld    (acc_vld),
    .row_hot    (row_hot),
    .col_hot    (col_hot)
);

// File: tb/muxaddr_ram_bench.sv
// Bench: behavioural model of the strobe/access protocol, compared every cycle.
module muxaddr_ram_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       ras = 1'b0, cas = 1'b0, en = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] mem [1024];
    logic [7:0] exp_rdata;
    logic       exp_rvalid;
    logic       m_ras_d, m_cas_d, m_row_ok;
    logic [4:0] m_row;
    logic       p_vld, p_rd, p_wr;
    int         p_addr;
    logic [7:0] p_wd;

    always #10 clk = ~clk;

    muxaddr_ram u_muxaddr_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .ras_i      (ras),
        .cas_i      (cas),
        .en_i       (en),
        .rd_i       (rd),
        .wr_i       (wr),
        .wr_data_i  (wdata),
        .rd_data_o  (rdata),
        .rd_valid_o (rvalid)
    );

    // Reference model: pending access executes, then new events are captured
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
            exp_rdata = 8'h00; exp_rvalid = 1'b0;
            m_ras_d = 1'b0; m_cas_d = 1'b0; m_row_ok = 1'b0; m_row = '0;
            p_vld = 1'b0; p_rd = 1'b0; p_wr = 1'b0; p_addr = 0; p_wd = '0;
        end else begin
            exp_rvalid = 1'b0;
            if (p_vld) begin
                if (p_rd) begin
                    exp_rdata  = mem[p_addr];
                    exp_rvalid = 1'b1;
                end
                if (p_wr) mem[p_addr] = p_wd;
            end
            p_vld  = cas && !m_cas_d && m_row_ok && en;
            p_addr = int'(m_row) * 32 + int'(addr);
            p_rd   = rd; p_wr = wr; p_wd = wdata;
            if (ras && !m_ras_d) begin
                m_row = addr; m_row_ok = 1'b1;
            end
            m_ras_d = ras; m_cas_d = cas;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        n_cmp++;
        if (rdata !== exp_rdata || rvalid !== exp_rvalid) begin
            n_bad++;
            $display("FAIL %s: actual data=%02h valid=%b expected data=%02h valid=%b",
                     cur_req, rdata, rvalid, exp_rdata, exp_rvalid);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic row_strobe(input logic [4:0] r);
        @(negedge clk); addr = r; ras = 1'b1;
        @(negedge clk); ras = 1'b0;
    endtask

    task automatic col_strobe(input logic [4:0] c, input logic e, input logic r,
                              input logic w, input logic [7:0] d);
        @(negedge clk); addr = c; cas = 1'b1; en = e; rd = r; wr = w; wdata = d;
        @(negedge clk); cas = 1'b0; en = 1'b0; rd = 1'b0; wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic access(input int a, input logic e, input logic r,
                          input logic w, input logic [7:0] d);
        row_strobe(5'(a >> 5));
        col_strobe(5'(a & 31), e, r, w, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: column event with no row yet is ignored
        cur_req = "R4";
        col_strobe(5'd3, 1'b1, 1'b1, 1'b1, 8'hAA);
        access(3, 1'b1, 1'b1, 1'b0, 8'h00);

        // R1: words read zero after reset
        cur_req = "R1";
        access(0, 1'b1, 1'b1, 1'b0, 8'h00);
        access(1023, 1'b1, 1'b1, 1'b0, 8'h00);

        // R2 R3 R5: write a spread of addresses
        cur_req = "R5";
        for (int i = 0; i < 64; i++)
            access((i * 37 + 5) % 1024, 1'b1, 1'b0, 1'b1, 8'((i * 29 + 3) & 255));
        access(1023, 1'b1, 1'b0, 1'b1, 8'hC3);
        access(0, 1'b1, 1'b0, 1'b1, 8'h5A);
        // R2 R3 R6: read them back
        cur_req = "R6";
        for (int i = 0; i < 64; i++)
            access((i * 37 + 5) % 1024, 1'b1, 1'b1, 1'b0, 8'h00);
        access(1023, 1'b1, 1'b1, 1'b0, 8'h00);
        access(0, 1'b1, 1'b1, 1'b0, 8'h00);

        // R11: only the crossing word is touched
        cur_req = "R11";
        access(10 * 32 + 20, 1'b1, 1'b0, 1'b1, 8'hE7);
        access(10 * 32 + 21, 1'b1, 1'b1, 1'b0, 8'h00);
        access(11 * 32 + 20, 1'b1, 1'b1, 1'b0, 8'h00);
        access(10 * 32 + 20, 1'b1, 1'b1, 1'b0, 8'h00);

        // R7: read and write together returns old data
        cur_req = "R7";
        access(500, 1'b1, 1'b1, 1'b1, 8'h3C);
        access(500, 1'b1, 1'b1, 1'b0, 8'h00);

        // R8: enable low, no write and data held
        cur_req = "R8";
        access(500, 1'b0, 1'b0, 1'b1, 8'hFF);
        access(500, 1'b0, 1'b1, 1'b0, 8'h00);
        access(500, 1'b1, 1'b1, 1'b0, 8'h00);

        // R9: enabled with no request
        cur_req = "R9";
        access(77, 1'b1, 1'b0, 1'b0, 8'h99);
        access(77, 1'b1, 1'b1, 1'b0, 8'h00);

        // R10: simultaneous row and column events use the older row
        cur_req = "R10";
        row_strobe(5'd4);
        @(negedge clk); addr = 5'd9; ras = 1'b1; cas = 1'b1; en = 1'b1; wr = 1'b1; wdata = 8'h61;
        @(negedge clk); ras = 1'b0; cas = 1'b0; en = 1'b0; wr = 1'b0;
        @(negedge clk);
        col_strobe(5'd9, 1'b1, 1'b1, 1'b0, 8'h00);
        access(4 * 32 + 9, 1'b1, 1'b1, 1'b0, 8'h00);

        // R12: held strobe counts once
        cur_req = "R12";
        row_strobe(5'd2);
        @(negedge clk); addr = 5'd6; cas = 1'b1; en = 1'b1; rd = 1'b1;
        repeat (4) @(negedge clk);
        cas = 1'b0; en = 1'b0; rd = 1'b0;
        repeat (3) @(negedge clk);

        // R3: back-to-back column events on one row
        cur_req = "R3";
        row_strobe(5'd31);
        col_strobe(5'd0, 1'b1, 1'b0, 1'b1, 8'h12);
        col_strobe(5'd31, 1'b1, 1'b0, 1'b1, 8'h34);
        col_strobe(5'd0, 1'b1, 1'b1, 1'b0, 8'h00);
        col_strobe(5'd31, 1'b1, 1'b1, 1'b0, 8'h00);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule